// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps the message-signalled interrupt table of a device function: for each of N vectors a 64-bit message address, a 32-bit message data word and a per-vector mask bit, plus a pending-bit array and the function-level enable and mask-all bits. Software reaches the table and the pending array through a 32-bit register port. The enable and mask-all bits arrive on a separate control write port.

Device logic raises interrupts by vector number. It also declares which vectors it actually uses by pulsing use and unuse strobes that drive a per-vector reference count. A request on a vector that is used and unmasked becomes a 64-bit address / 32-bit data write on a valid/ready message port. A request on a masked vector is parked as a pending bit. The parked message goes out automatically as soon as the vector becomes unmasked, either through a table write or through a control write that lifts the function mask.

When a control write changes the function mask while the function is enabled, a small sequencer walks every vector once, one per cycle, and raises a busy flag for that time. The sources of register writes, control writes and interrupt requests must hold off while busy is high.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset the table reads as zero except that bit 0 of every vector-control word reads 1; the pending array reads zero; enable and mask-all are clear; msgValid and busy are low; all use counts are zero.
- R2: Table window word address is {vector, word}, with word 0 = address bits 31:0, 1 = address bits 63:32, 2 = message data, 3 = vector control; only bit 0 of the control word is stored and the other control bits read 0.
- R3: PBA window word w bit b reports the pending bit of vector 32*w+b (0 for vectors at or above N); writes to the PBA window change nothing.
- R4: The function is masked when enable is 0 or mask-all is 1; a request on a used vector that is masked (function or own bit) sets its pending bit and sends no message.
- R5: A request on a used, unmasked vector sends one message carrying that vector's current address and data, with msgVec equal to the vector.
- R6: A request with a vector number at or above N, or on a vector whose use count is zero, changes nothing and sends nothing.
- R7: A vector-control write that turns a masked vector unmasked while its pending bit is set clears the pending bit and sends that vector's message.
- R8: A control write with enable 1 pulses intxDeassert for one cycle; if it also changes the function mask, busy stays high for exactly N cycles while every vector is re-checked in ascending order, and each newly unmasked pending vector is replayed.
- R9: Use strobes increment a vector's count, unuse strobes decrement a nonzero count and do nothing at zero; the pending bit clears when the count reaches zero.
- R10: While msgValid is high and msgReady low the message is held unchanged; queued messages leave in ascending vector order.
- R11: tableSize reads N-1; N is limited to 1..2048.
- R12: When a control-word write and a request hit the same vector in the same cycle, the request sees the newly written mask bit.
- R13: While busy is high, register writes, control writes and requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 = write, 0 = read |
| regIsPba | input | 1 | 1 = PBA window, 0 = table window |
| regAddr | input | REG_AW | 32-bit word address inside the window |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the addressed word |
| ctlWe | input | 1 | Control write strobe |
| ctlEnable | input | 1 | New enable bit |
| ctlMaskAll | input | 1 | New mask-all bit |
| irqValid | input | 1 | Interrupt request strobe |
| irqVec | input | 11 | Requested vector number |
| useStb | input | 1 | Increment use count of cntVec |
| unuseStb | input | 1 | Decrement use count of cntVec |
| cntVec | input | 11 | Vector for use/unuse |
| msgValid | output | 1 | Message write valid |
| msgReady | input | 1 | Message write accepted |
| msgAddr | output | 64 | Message address |
| msgData | output | 32 | Message data |
| msgVec | output | 11 | Vector the message belongs to |
| intxDeassert | output | 1 | One-cycle legacy interrupt deassert pulse |
| busy | output | 1 | Vector re-check in progress |
| tableSize | output | 11 | N-1 |

## Verification
Two functions can collide on one vector in one cycle: a vector-control write that unmasks it and an interrupt request for it. The bench drives both strobes in the same cycle and judges the outcome at the ports. Exactly one message must leave and the pending array must read zero afterwards. If the request were evaluated against the stale mask, the pending bit would stay set on an unmasked vector. Contention on the message port is also provoked: a replayed message and new requests queue behind a stalled receiver, and the order of the log is compared once ready returns.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam int MAX_VECTORS = 2048;
  localparam int IDX_W = 11;

  localparam logic [1:0] W_ADDR_LO = 2'd0;
  localparam logic [1:0] W_ADDR_HI = 2'd1;
  localparam logic [1:0] W_DATA    = 2'd2;
  localparam logic [1:0] W_CTRL    = 2'd3;

  typedef enum logic {ST_IDLE, ST_SWEEP} sweep_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             setPend;
    logic [IDX_W-1:0] setIdx;
    logic             clrPend;
    logic [IDX_W-1:0] clrIdx;
  } pend_cmd_t;
endpackage

// File: rtl/msix_datapath.sv
module msix_datapath
  import msix_pkg::*;
#(
  parameter int NUM_VEC   = 8,
  parameter int USE_CNT_W = 4,
  parameter int VEC_W     = 3,
  parameter int TAB_AW    = 5,
  parameter int REG_AW    = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tblWe,
  input  logic               regIsPba,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  pend_cmd_t          cmd,
  input  logic               useStb,
  input  logic               unuseStb,
  input  logic [IDX_W-1:0]   cntVec,
  input  logic [VEC_W-1:0]   selIdx,
  output logic [63:0]        selAddr,
  output logic [31:0]        selData,
  output logic [NUM_VEC-1:0] maskVec,
  output logic [NUM_VEC-1:0] pendVec,
  output logic [NUM_VEC-1:0] usedVec
);
  logic [31:0] addrLo [NUM_VEC];
  logic [31:0] addrHi [NUM_VEC];
  logic [31:0] msgWord [NUM_VEC];
  logic [USE_CNT_W-1:0] useCnt [NUM_VEC];

  logic [TAB_AW-1:0] tAddr;
  logic [VEC_W-1:0]  tVec;
  logic [1:0]        tSel;
  logic              tVecOk;

  assign tAddr  = regAddr[TAB_AW-1:0];
  assign tVec   = tAddr[TAB_AW-1:2];
  assign tSel   = tAddr[1:0];
  assign tVecOk = 32'(tVec) < NUM_VEC;

  // table storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        addrLo[i]  <= '0;
        addrHi[i]  <= '0;
        msgWord[i] <= '0;
      end
      maskVec <= '1;
    end else if (tblWe && tVecOk) begin
      case (tSel)
        W_ADDR_LO: addrLo[tVec]  <= regWrData;
        W_ADDR_HI: addrHi[tVec]  <= regWrData;
        W_DATA:    msgWord[tVec] <= regWrData;
        default:   maskVec[tVec] <= regWrData[0];
      endcase
    end
  end

  // use counters
  logic [VEC_W-1:0] cv;
  logic             cvOk;
  logic             incHit;
  logic             decHit;
  logic             zeroHit;

  assign cv      = cntVec[VEC_W-1:0];
  assign cvOk    = 32'(cntVec) < NUM_VEC;
  assign incHit  = cvOk && useStb && !unuseStb && (useCnt[cv] != '1);
  assign decHit  = cvOk && unuseStb && !useStb && (useCnt[cv] != '0);
  assign zeroHit = decHit && (useCnt[cv] == USE_CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_VEC; i++) useCnt[i] <= '0;
    end else if (incHit) begin
      useCnt[cv] <= useCnt[cv] + USE_CNT_W'(1);
    end else if (decHit) begin
      useCnt[cv] <= useCnt[cv] - USE_CNT_W'(1);
    end
  end

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_used
    assign usedVec[g] = |useCnt[g];
  end

  // pending bits: clear wins over set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendVec <= '0;
    end else begin
      for (int i = 0; i < NUM_VEC; i++) begin
        if (cmd.setPend && cmd.setIdx == IDX_W'(i)) pendVec[i] <= 1'b1;
        if ((cmd.clrPend && cmd.clrIdx == IDX_W'(i)) ||
            (zeroHit && cv == VEC_W'(i)))
          pendVec[i] <= 1'b0;
      end
    end
  end

  // read mux
  always_comb begin
    regRdData = '0;
    if (regIsPba) begin
      for (int b = 0; b < 32; b++) begin
        if (int'(regAddr) * 32 + b < NUM_VEC)
          regRdData[b] = pendVec[int'(regAddr) * 32 + b];
      end
    end else if (tVecOk) begin
      case (tSel)
        W_ADDR_LO: regRdData = addrLo[tVec];
        W_ADDR_HI: regRdData = addrHi[tVec];
        W_DATA:    regRdData = msgWord[tVec];
        default:   regRdData = {31'd0, maskVec[tVec]};
      endcase
    end
  end

  assign selAddr = {addrHi[selIdx], addrLo[selIdx]};
  assign selData = msgWord[selIdx];
endmodule

// File: rtl/msix_control.sv
module msix_control
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int VEC_W   = 3,
  parameter int TAB_AW  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic               regIsPba,
  input  logic [TAB_AW-1:0]  tabAddr,
  input  logic               wrMaskBit,
  input  logic               ctlWe,
  input  logic               ctlEnable,
  input  logic               ctlMaskAll,
  input  logic               irqValid,
  input  logic [IDX_W-1:0]   irqVec,
  input  logic [NUM_VEC-1:0] maskVec,
  input  logic [NUM_VEC-1:0] pendVec,
  input  logic [NUM_VEC-1:0] usedVec,
  input  logic [63:0]        selAddr,
  input  logic [31:0]        selData,
  input  logic               msgReady,
  output pend_cmd_t          cmd,
  output logic               tblWe,
  output logic [VEC_W-1:0]   selIdx,
  output logic               msgValid,
  output logic [63:0]        msgAddr,
  output logic [31:0]        msgData,
  output logic [IDX_W-1:0]   msgVec,
  output logic               intxDeassert,
  output logic               busy,
  output logic               fnMasked,
  output logic               fnEnabled
);
  sweep_state_e     state;
  logic             maskAllReg;
  logic             oldFn;
  logic [VEC_W-1:0] sweepIdx;

  assign busy     = (state == ST_SWEEP);
  assign fnMasked = !fnEnabled || maskAllReg;

  // table-side decode
  logic [VEC_W-1:0] wVec;
  logic             wVecOk;
  logic             ctrlWr;
  logic             wrReplay;

  assign tblWe   = regValid && regWrite && !regIsPba && !busy;
  assign wVec    = tabAddr[TAB_AW-1:2];
  assign wVecOk  = 32'(wVec) < NUM_VEC;
  assign ctrlWr  = tblWe && wVecOk && (tabAddr[1:0] == W_CTRL);
  assign wrReplay = ctrlWr && (fnMasked || maskVec[wVec]) &&
                    !(fnMasked || wrMaskBit) && pendVec[wVec];

  // request decode, sees a same-cycle mask write
  logic [VEC_W-1:0] irqIdx;
  logic             irqAcc;
  logic             irqMasked;

  assign irqIdx    = irqVec[VEC_W-1:0];
  assign irqAcc    = irqValid && !busy && (32'(irqVec) < NUM_VEC) && usedVec[irqIdx];
  assign irqMasked = fnMasked ||
                     ((ctrlWr && wVec == irqIdx) ? wrMaskBit : maskVec[irqIdx]);

  // sweep decode
  logic sweepReplay;
  assign sweepReplay = busy && (oldFn || maskVec[sweepIdx]) &&
                       !(fnMasked || maskVec[sweepIdx]) && pendVec[sweepIdx];

  always_comb begin
    cmd.setPend = irqAcc && irqMasked;
    cmd.setIdx  = irqVec;
    cmd.clrPend = wrReplay || sweepReplay;
    cmd.clrIdx  = busy ? IDX_W'(sweepIdx) : IDX_W'(wVec);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      fnEnabled    <= 1'b0;
      maskAllReg   <= 1'b0;
      oldFn        <= 1'b1;
      sweepIdx     <= '0;
      intxDeassert <= 1'b0;
    end else begin
      intxDeassert <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ctlWe) begin
            fnEnabled    <= ctlEnable;
            maskAllReg   <= ctlMaskAll;
            intxDeassert <= ctlEnable;
            if (ctlEnable && (ctlMaskAll != fnMasked)) begin
              state    <= ST_SWEEP;
              sweepIdx <= '0;
              oldFn    <= fnMasked;
            end
          end
        end
        default: begin
          if (sweepIdx == VEC_W'(NUM_VEC - 1)) state <= ST_IDLE;
          else sweepIdx <= sweepIdx + VEC_W'(1);
        end
      endcase
    end
  end

  // send queue
  logic [NUM_VEC-1:0] queued;
  logic [NUM_VEC-1:0] qSet;
  logic [NUM_VEC-1:0] takeMask;
  logic               pickHit;
  logic               load;

  always_comb begin
    qSet = '0;
    if (irqAcc && !irqMasked) qSet[irqIdx]  = 1'b1;
    if (wrReplay)             qSet[wVec]    = 1'b1;
    if (sweepReplay)          qSet[sweepIdx] = 1'b1;
  end

  always_comb begin
    pickHit = 1'b0;
    selIdx  = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (queued[i]) begin
        pickHit = 1'b1;
        selIdx  = VEC_W'(i);
      end
    end
  end

  assign load     = pickHit && (!msgValid || msgReady);
  assign takeMask = load ? (NUM_VEC'(1) << selIdx) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      queued   <= '0;
      msgValid <= 1'b0;
      msgAddr  <= '0;
      msgData  <= '0;
      msgVec   <= '0;
    end else begin
      queued <= (queued & ~takeMask) | qSet;
      if (load) begin
        msgValid <= 1'b1;
        msgAddr  <= selAddr;
        msgData  <= selData;
        msgVec   <= IDX_W'(selIdx);
      end else if (msgReady) begin
        msgValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
  import msix_pkg::*;
#(
  parameter int NUM_VEC   = 8,
  parameter int USE_CNT_W = 4,
  localparam int VEC_W     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int TAB_AW    = VEC_W + 2,
  localparam int PBA_WORDS = ((NUM_VEC + 63) / 64) * 2,
  localparam int PBA_AW    = (PBA_WORDS > 1) ? $clog2(PBA_WORDS) : 1,
  localparam int REG_AW    = (TAB_AW > PBA_AW) ? TAB_AW : PBA_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic              regIsPba,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              ctlWe,
  input  logic              ctlEnable,
  input  logic              ctlMaskAll,
  input  logic              irqValid,
  input  logic [10:0]       irqVec,
  input  logic              useStb,
  input  logic              unuseStb,
  input  logic [10:0]       cntVec,
  output logic              msgValid,
  input  logic              msgReady,
  output logic [63:0]       msgAddr,
  output logic [31:0]       msgData,
  output logic [10:0]       msgVec,
  output logic              intxDeassert,
  output logic              busy,
  output logic [10:0]       tableSize
);
  pend_cmd_t          cmd;
  logic               tblWe;
  logic [VEC_W-1:0]   selIdx;
  logic [63:0]        selAddr;
  logic [31:0]        selData;
  logic [NUM_VEC-1:0] maskVec;
  logic [NUM_VEC-1:0] pendVec;
  logic [NUM_VEC-1:0] usedVec;
  logic               fnMasked;
  logic               fnEnabled;

  assign tableSize = IDX_W'(NUM_VEC - 1);

  msix_control #(
    .NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .TAB_AW(TAB_AW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regValid(regValid), .regWrite(regWrite), .regIsPba(regIsPba),
    .tabAddr(regAddr[TAB_AW-1:0]), .wrMaskBit(regWrData[0]),
    .ctlWe(ctlWe), .ctlEnable(ctlEnable), .ctlMaskAll(ctlMaskAll),
    .irqValid(irqValid), .irqVec(irqVec),
    .maskVec(maskVec), .pendVec(pendVec), .usedVec(usedVec),
    .selAddr(selAddr), .selData(selData), .msgReady(msgReady),
    .cmd(cmd), .tblWe(tblWe), .selIdx(selIdx),
    .msgValid(msgValid), .msgAddr(msgAddr), .msgData(msgData), .msgVec(msgVec),
    .intxDeassert(intxDeassert), .busy(busy),
    .fnMasked(fnMasked), .fnEnabled(fnEnabled)
  );

  msix_datapath #(
    .NUM_VEC(NUM_VEC), .USE_CNT_W(USE_CNT_W), .VEC_W(VEC_W),
    .TAB_AW(TAB_AW), .REG_AW(REG_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .tblWe(tblWe), .regIsPba(regIsPba), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .cmd(cmd), .useStb(useStb), .unuseStb(unuseStb), .cntVec(cntVec),
    .selIdx(selIdx), .selAddr(selAddr), .selData(selData),
    .maskVec(maskVec), .pendVec(pendVec), .usedVec(usedVec)
  );
endmodule

// File: rtl/msix_vec_ctrl_chk.sv
module msix_vec_ctrl_chk #(
  parameter int NUM_VEC = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               msgValid,
  input logic               msgReady,
  input logic [10:0]        msgVec,
  input logic [63:0]        msgAddr,
  input logic [31:0]        msgData,
  input logic               busy,
  input logic               intxDeassert,
  input logic [NUM_VEC-1:0] pendVec,
  input logic [NUM_VEC-1:0] maskVec,
  input logic [NUM_VEC-1:0] usedVec,
  input logic               fnMasked,
  input logic               fnEnabled
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> ((&maskVec) && (pendVec == '0) && !msgValid && !busy));

  // R10
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgVec) &&
                                 $stable(msgAddr) && $stable(msgData)));

  // R13
  busy_no_new_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ((pendVec & ~$past(pendVec)) == '0));

  // R9
  pend_needs_use_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & ~usedVec) == '0));

  // R7
  pend_only_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> ((pendVec & ~(maskVec | {NUM_VEC{fnMasked}})) == '0));

  // R8
  intx_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    intxDeassert |-> fnEnabled);
endmodule

bind msix_vec_ctrl msix_vec_ctrl_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgReady(msgReady),
  .msgVec(msgVec), .msgAddr(msgAddr), .msgData(msgData), .busy(busy),
  .intxDeassert(intxDeassert), .pendVec(pendVec), .maskVec(maskVec),
  .usedVec(usedVec), .fnMasked(fnMasked), .fnEnabled(fnEnabled)
);

// File: tb/msix_vec_ctrl_bench.sv
module msix_vec_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0, regWrite = 1'b0, regIsPba = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        ctlWe = 1'b0, ctlEnable = 1'b0, ctlMaskAll = 1'b0;
  logic        irqValid = 1'b0;
  logic [10:0] irqVec = '0;
  logic        useStb = 1'b0, unuseStb = 1'b0;
  logic [10:0] cntVec = '0;
  logic        msgValid, msgReady = 1'b1;
  logic [63:0] msgAddr;
  logic [31:0] msgData;
  logic [10:0] msgVec;
  logic        intxDeassert, busy;
  logic [10:0] tableSize;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  msix_vec_ctrl u_msix_vec_ctrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regIsPba(regIsPba), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .ctlWe(ctlWe), .ctlEnable(ctlEnable),
    .ctlMaskAll(ctlMaskAll), .irqValid(irqValid), .irqVec(irqVec),
    .useStb(useStb), .unuseStb(unuseStb), .cntVec(cntVec),
    .msgValid(msgValid), .msgReady(msgReady), .msgAddr(msgAddr),
    .msgData(msgData), .msgVec(msgVec), .intxDeassert(intxDeassert),
    .busy(busy), .tableSize(tableSize)
  );

  // message log, taken at the handshake edge
  logic [10:0] logVec [64];
  logic [63:0] logAddr [64];
  logic [31:0] logData [64];
  int logCnt = 0;

  always @(posedge clk) begin
    if (rstN && msgValid && msgReady && logCnt < 64) begin
      logVec[logCnt]  <= msgVec;
      logAddr[logCnt] <= msgAddr;
      logData[logCnt] <= msgData;
      logCnt <= logCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit pba, input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regIsPba = pba; regAddr = a; regWrData = d;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rd(input bit pba, input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regIsPba = pba; regAddr = a;
    #1 d = regRdData;
    regValid = 1'b0;
  endtask

  task automatic ctl(input bit en, input bit ma);
    @(negedge clk);
    ctlWe = 1'b1; ctlEnable = en; ctlMaskAll = ma;
    @(negedge clk);
    ctlWe = 1'b0;
  endtask

  task automatic irq(input logic [10:0] v);
    @(negedge clk);
    irqValid = 1'b1; irqVec = v;
    @(negedge clk);
    irqValid = 1'b0;
  endtask

  task automatic cnt(input bit up, input logic [10:0] v);
    @(negedge clk);
    useStb = up; unuseStb = !up; cntVec = v;
    @(negedge clk);
    useStb = 1'b0; unuseStb = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
  endtask

  task automatic chkPba(input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd(1'b1, 5'd0, d);
    chk(d == exp, tag, {32'd0, d}, {32'd0, exp});
  endtask

  task automatic chkMsg(input int k, input int v, input string tag);
    logic [63:0] ea;
    ea = {32'hA0 + 32'(v), 32'h1000 + 32'(v) * 16};
    chk(logVec[k] == 11'(v), {tag, " vec"}, 64'(logVec[k]), 64'(v));
    chk(logAddr[k] == ea, {tag, " addr"}, logAddr[k], ea);
    chk(logData[k] == 32'hD000 + 32'(v), {tag, " data"}, 64'(logData[k]),
        64'(32'hD000 + 32'(v)));
  endtask

  // R2 stimulus table: {word address, write data, expected read}
  localparam logic [71:0] REG_TBL [7] = '{
    {8'h08, 32'h12345678, 32'h12345678},
    {8'h09, 32'h9ABCDEF0, 32'h9ABCDEF0},
    {8'h0A, 32'hCAFEF00D, 32'hCAFEF00D},
    {8'h0B, 32'hFFFFFFFE, 32'h00000000},
    {8'h0B, 32'h00000003, 32'h00000001},
    {8'h1F, 32'h00000000, 32'h00000000},
    {8'h1E, 32'h0BADBEEF, 32'h0BADBEEF}
  };

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R11 reset state
    rd(1'b0, 5'h03, d); chk(d == 1, "R1 ctrl v0", 64'(d), 1);
    rd(1'b0, 5'h1F, d); chk(d == 1, "R1 ctrl v7", 64'(d), 1);
    rd(1'b0, 5'h10, d); chk(d == 0, "R1 addrLo v4", 64'(d), 0);
    chkPba(32'h0, "R1 pba");
    chk(!msgValid && !busy && !intxDeassert, "R1 outputs", {msgValid, busy, intxDeassert}, 0);
    chk(tableSize == 11'd7, "R11 tableSize", 64'(tableSize), 7);

    // R2 table walk
    for (int i = 0; i < 7; i++) begin
      wr(1'b0, REG_TBL[i][68:64], REG_TBL[i][63:32]);
      rd(1'b0, REG_TBL[i][68:64], d);
      chk(d == REG_TBL[i][31:0], "R2 table word", 64'(d), 64'(REG_TBL[i][31:0]));
    end

    // program all vectors, unmask each (function still masked)
    for (int v = 0; v < 8; v++) begin
      wr(1'b0, {3'(v), 2'd0}, 32'h1000 + 32'(v) * 16);
      wr(1'b0, {3'(v), 2'd1}, 32'hA0 + 32'(v));
      wr(1'b0, {3'(v), 2'd2}, 32'hD000 + 32'(v));
      wr(1'b0, {3'(v), 2'd3}, 32'h0);
    end
    for (int v = 0; v < 6; v++) cnt(1'b1, 11'(v));
    cnt(1'b1, 11'd3);

    // R4 requests with function disabled
    irq(11'd1);
    irq(11'd2);
    settle();
    chkPba(32'h6, "R4 pending");
    chk(logCnt == 0, "R4 no message", 64'(logCnt), 0);

    // R6 dropped requests
    irq(11'd6);
    irq(11'd9);
    settle();
    chkPba(32'h6, "R6 dropped");

    // R3 PBA write ignored
    wr(1'b1, 5'd0, 32'h0);
    chkPba(32'h6, "R3 pba write ignored");

    // R8 enable: pulse, sweep length, replay order
    ctl(1'b1, 1'b0);
    chk(intxDeassert == 1'b1, "R8 intx pulse", 64'(intxDeassert), 1);
    n = 0;
    for (int i = 0; i < 40 && busy; i++) begin
      n++;
      @(negedge clk);
    end
    chk(n == 8, "R8 busy cycles", 64'(n), 8);
    settle();
    chk(logCnt == 2, "R8 replay count", 64'(logCnt), 2);
    chkMsg(0, 1, "R8 replay first");
    chkMsg(1, 2, "R8 replay second");
    chkPba(32'h0, "R8 pba cleared");

    // R5 live request
    irq(11'd0);
    settle();
    chk(logCnt == 3, "R5 count", 64'(logCnt), 3);
    chkMsg(2, 0, "R5 message");
    irq(11'd6);
    settle();
    chk(logCnt == 3, "R6 unused enabled", 64'(logCnt), 3);

    // R7 per-vector mask then unmask
    wr(1'b0, 5'h13, 32'h1);
    irq(11'd4);
    settle();
    chkPba(32'h10, "R7 pend on masked");
    chk(logCnt == 3, "R7 held", 64'(logCnt), 3);
    wr(1'b0, 5'h13, 32'h0);
    settle();
    chk(logCnt == 4, "R7 replay count", 64'(logCnt), 4);
    chkMsg(3, 4, "R7 replay");
    chkPba(32'h0, "R7 pba cleared");

    // R9 use counting
    wr(1'b0, 5'h0F, 32'h1);
    irq(11'd3);
    settle();
    chkPba(32'h8, "R9 pend v3");
    cnt(1'b0, 11'd3);
    chkPba(32'h8, "R9 count 1 keeps pend");
    cnt(1'b0, 11'd3);
    chkPba(32'h0, "R9 count 0 clears pend");
    cnt(1'b0, 11'd3);
    irq(11'd3);
    wr(1'b0, 5'h0F, 32'h0);
    settle();
    chkPba(32'h0, "R9 unused dropped");
    chk(logCnt == 4, "R9 no message", 64'(logCnt), 4);

    // R10 hold and ordering under backpressure
    msgReady = 1'b0;
    irq(11'd5);
    settle();
    chk(msgValid && msgVec == 11'd5, "R10 presented", 64'(msgVec), 5);
    irq(11'd2);
    irq(11'd1);
    repeat (3) @(negedge clk);
    chk(msgValid && msgVec == 11'd5, "R10 held", 64'(msgVec), 5);
    msgReady = 1'b1;
    settle();
    chk(logCnt == 7, "R10 count", 64'(logCnt), 7);
    chkMsg(4, 5, "R10 first");
    chkMsg(5, 1, "R10 lower next");
    chkMsg(6, 2, "R10 last");

    // R12 unmask write and request in one cycle
    wr(1'b0, 5'h03, 32'h1);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regIsPba = 1'b0; regAddr = 5'h03; regWrData = 32'h0;
    irqValid = 1'b1; irqVec = 11'd0;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0; irqValid = 1'b0;
    settle();
    chk(logCnt == 8, "R12 one message", 64'(logCnt), 8);
    chkMsg(7, 0, "R12 message");
    chkPba(32'h0, "R12 no pend");

    // R13 accesses during busy are ignored
    ctl(1'b1, 1'b1);
    chk(busy == 1'b1, "R13 busy", 64'(busy), 1);
    wr(1'b0, 5'h00, 32'h00000BAD);
    irq(11'd1);
    waitIdle();
    rd(1'b0, 5'h00, d);
    chk(d == 32'h1000, "R13 write ignored", 64'(d), 64'h1000);
    chkPba(32'h0, "R13 request ignored");

    // R4 / R8 mask-all pending, lifted by control write
    irq(11'd1);
    settle();
    chkPba(32'h2, "R4 mask-all pend");
    ctl(1'b1, 1'b0);
    waitIdle();
    settle();
    chk(logCnt == 9, "R8 mask-all replay", 64'(logCnt), 9);
    chkMsg(8, 1, "R8 mask-all msg");

    // R8 disabling write: no pulse
    ctl(1'b0, 1'b0);
    chk(intxDeassert == 1'b0, "R8 no pulse on disable", 64'(intxDeassert), 0);

    // R1 reset in the middle of operation
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    rd(1'b0, 5'h0B, d); chk(d == 1, "R1 ctrl after reset", 64'(d), 1);
    rd(1'b0, 5'h08, d); chk(d == 0, "R1 addr after reset", 64'(d), 0);
    chkPba(32'h0, "R1 pba after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule